// File: doc/BRIEF.md
# SAR Conversion Start Sequencer

This block runs one successive-approximation conversion at a time for a 12-bit converter. Two active-low select inputs, chip select and read/convert, are ORed into a single request strobe. A falling edge of that strobe starts a conversion while the sequencer is idle and power-down is low. Busy then goes low. The sequencer drives a trial code toward the DAC one bit at a time, from the most significant bit down to bit zero, and keeps or drops each bit according to a comparator input. When all bits are resolved it copies the code into a result register and pulses a load strobe toward the output shift register. Busy returns high on the same clock edge that stores the result.

Each bit trial lasts a parameter number of clock cycles. A conversion therefore keeps busy low for 12 trials plus one latch cycle. The strobe may still be low during the latch cycle. In that case a new conversion begins at once with no acquisition gap and busy stays low. Power-down blocks new starts. Raising it during a conversion abandons the conversion, and the result of the previous conversion is kept.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion starts only on a clock where the ORed strobe (cs_n OR rc_n) has gone from 1 to 0 since the previous clock, the block is idle and pwrdn is 0. busy_o reads 0 in the cycle after that edge. A falling rc_n while cs_n is 1 starts nothing.
- R2: From the start, busy_o stays 0 for exactly 12*CYC_PER_BIT+1 cycles, where CYC_PER_BIT is the number of clock cycles per bit trial. load_o is 1 only in the last of those cycles. result_o takes the new code on the edge where busy_o returns to 1.
- R3: The first trial code after a start is 12'h800. Each bit is tested from bit 11 down to bit 0. A bit is kept when cmp_ge is 1 in the last cycle of its trial and cleared otherwise. With cmp_ge = (input >= trial_o), the result equals the input code.
- R4: A new falling edge of the strobe while a conversion is running has no effect on its length or its result.
- R5: If the strobe is still low in the load cycle, busy_o stays 0 and a new conversion begins in the next cycle with trial_o = 12'h800. result_o holds the code just converted.
- R6: While pwrdn is 1 an idle block ignores strobe edges, busy_o stays 1 and result_o keeps its value.
- R7: If pwrdn rises during the trial phase, busy_o is 1 in the next cycle, trial_o is 0, no load pulse is produced and result_o is unchanged.
- R8: After reset busy_o is 1, result_o and trial_o are 0 and load_o is 0.
- R9: trial_o is 0 whenever busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rc_n | input | 1 | Read/convert request, active low |
| pwrdn | input | 1 | Power-down; blocks starts and abandons a running conversion |
| cmp_ge | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| busy_o | output | 1 | High when idle, low during a conversion |
| trial_o | output | NBITS | Trial code toward the DAC |
| result_o | output | NBITS | Last completed conversion result |
| load_o | output | 1 | One-cycle strobe in the latch cycle, toward the output shift register |

## Verification
The checker watches every cycle for these rules:
- load only appears while busy is low;
- busy only rises after a load or under power-down;
- the result changes only after a load;
- every conversion opens with the MSB trial;
- power-down keeps an idle block idle and aborts a running trial;
- the trial code is clear while idle.

The exact busy window length, the bit-by-bit decisions that give the final code, the OR'd start with chip select, ignored mid-conversion edges and the back-to-back restart are shown only by the bench's scenarios. The largest of these scenarios sweeps all 4096 input codes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int SAR_BITS    = 12;
    localparam int SAR_CYC_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_LATCH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic start;  // load MSB trial
        logic step;   // resolve current bit
        logic clear;  // return code to zero
        logic keep;   // decision for current bit
    } sar_ctl_t;

endpackage

// File: rtl/sar_strobe_edge.sv
module sar_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rc_n,
    output logic strobe_low,
    output logic strobe_fall
);
    logic strobe;
    logic strobe_q;

    assign strobe = cs_n | rc_n;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b1;
        else     strobe_q <= strobe;
    end

    assign strobe_low  = ~strobe;
    assign strobe_fall = strobe_q & ~strobe;
endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
    parameter int NBITS       = sar_seq_pkg::SAR_BITS,
    parameter int CYC_PER_BIT = sar_seq_pkg::SAR_CYC_BIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     run,
    output logic                     step_done,
    output logic                     last_bit,
    output logic [$clog2(NBITS)-1:0] bit_idx
);
    localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam int IW = $clog2(NBITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(CYC_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_TOP  = IW'(NBITS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt     <= '0;
            bit_idx <= IDX_TOP;
        end else if (run) begin
            if (cnt == CNT_LAST) begin
                cnt <= '0;
                if (bit_idx != '0) bit_idx <= bit_idx - IW'(1);
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign step_done = run && (cnt == CNT_LAST);
    assign last_bit  = (bit_idx == '0);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int NBITS = sar_seq_pkg::SAR_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  sar_seq_pkg::sar_ctl_t    ctl,
    input  logic [$clog2(NBITS)-1:0] bit_idx,
    output logic [NBITS-1:0]         code
);
    localparam int IW = $clog2(NBITS);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (ctl.start) begin
            code <= MSB_ONLY;
        end else if (ctl.clear) begin
            code <= '0;
        end else if (ctl.step) begin
            code[bit_idx] <= ctl.keep;
            if (bit_idx != '0) code[bit_idx - IW'(1)] <= 1'b1;
        end
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int NBITS       = sar_seq_pkg::SAR_BITS,
    parameter int CYC_PER_BIT = sar_seq_pkg::SAR_CYC_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rc_n,
    input  logic             pwrdn,
    input  logic             cmp_ge,
    output logic             busy_o,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] result_o,
    output logic             load_o
);
    import sar_seq_pkg::*;

    localparam int IW = $clog2(NBITS);

    seq_state_e      st, st_nxt;
    logic            strobe_low, strobe_fall;
    logic            step_done, last_bit;
    logic [IW-1:0]   bit_idx;
    logic [NBITS-1:0] code;
    logic            start_go, abort;
    sar_ctl_t        ctl;

    sar_strobe_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .rc_n        (rc_n),
        .strobe_low  (strobe_low),
        .strobe_fall (strobe_fall)
    );

    // Start from idle on a fresh edge, or restart from the latch cycle on a held-low strobe
    assign start_go = !pwrdn &&
                      (((st == ST_IDLE) && strobe_fall) ||
                       ((st == ST_LATCH) && strobe_low));
    assign abort    = (st == ST_TRIAL) && pwrdn;

    sar_step_timer #(.NBITS(NBITS), .CYC_PER_BIT(CYC_PER_BIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_go),
        .run       (st == ST_TRIAL),
        .step_done (step_done),
        .last_bit  (last_bit),
        .bit_idx   (bit_idx)
    );

    always_comb begin
        ctl.start = start_go;
        ctl.step  = step_done && !abort;
        ctl.clear = abort || ((st == ST_LATCH) && !start_go);
        ctl.keep  = cmp_ge;
    end

    sar_approx_reg #(.NBITS(NBITS)) u_sar (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .bit_idx (bit_idx),
        .code    (code)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start_go) st_nxt = ST_TRIAL;
            ST_TRIAL: begin
                if (abort)                      st_nxt = ST_IDLE;
                else if (step_done && last_bit) st_nxt = ST_LATCH;
            end
            ST_LATCH: st_nxt = start_go ? ST_TRIAL : ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)                 result_o <= '0;
        else if (st == ST_LATCH) result_o <= code;
    end

    assign busy_o  = (st == ST_IDLE);
    assign load_o  = (st == ST_LATCH);
    assign trial_o = code;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS = sar_seq_pkg::SAR_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             pwrdn,
    input logic             busy_o,
    input logic             load_o,
    input logic [NBITS-1:0] trial_o,
    input logic [NBITS-1:0] result_o
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    AST_LOAD_WHILE_CONVERTING: assert property (@(posedge clk) disable iff (rst)
        load_o |-> !busy_o); // R2

    AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(load_o) || $past(pwrdn))); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !load_o |=> $stable(result_o)); // R6

    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (trial_o == MSB_ONLY)); // R3

    AST_PD_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pwrdn) |=> busy_o); // R6

    AST_PD_ABORT: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_o && pwrdn) |=> busy_o); // R7

    AST_IDLE_TRIAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (trial_o == '0)); // R9
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwrdn    (pwrdn),
    .busy_o   (busy_o),
    .load_o   (load_o),
    .trial_o  (trial_o),
    .result_o (result_o)
);

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 12;
    localparam int CYC        = 2;
    localparam int TRIALS     = NB * CYC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b0;
    logic          rc_n = 1'b1;
    logic          pwrdn = 1'b0;
    logic [NB-1:0] vin = '0;
    logic          cmp_ge;
    logic          busy_o, load_o;
    logic [NB-1:0] trial_o, result_o;

    int checks   = 0;
    int failures = 0;
    logic [NB-1:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_ge = (vin >= trial_o);

    sar_seq_ctrl #(.NBITS(NB), .CYC_PER_BIT(CYC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .pwrdn(pwrdn),
        .cmp_ge(cmp_ge), .busy_o(busy_o), .trial_o(trial_o),
        .result_o(result_o), .load_o(load_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full conversion; optional extra strobe edge mid-way (R4)
    task automatic run_conv(input logic [NB-1:0] v, input bit glitch);
        bit ok_win;
        logic [NB-1:0] exp_second;
        @(negedge clk); vin = v; rc_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy low after start", busy_o, 0);
        chk(trial_o == 12'h800, "R3 first trial MSB", trial_o, 12'h800);
        ok_win = 1'b1;
        exp_second = (v[NB-1] ? 12'h800 : 12'h000) | 12'h400;
        for (int i = 1; i <= TRIALS; i++) begin
            @(negedge clk);
            if (busy_o !== 1'b0 || load_o !== (i == TRIALS)) ok_win = 1'b0;
            if (i == CYC)
                chk(trial_o == exp_second, "R3 second trial", trial_o, exp_second);
            if (!glitch && i == 1) rc_n = 1'b1;
            if (glitch && i == 3) rc_n = 1'b1;
            if (glitch && i == 4) rc_n = 1'b0;
            if (glitch && i == 6) rc_n = 1'b1;
        end
        chk(ok_win, glitch ? "R4 window with extra edge" : "R2 busy window and load", ok_win, 1);
        @(negedge clk);
        chk(busy_o == 1'b1, "R2 busy high after load", busy_o, 1);
        chk(result_o == v, glitch ? "R4 result" : "R3 result equals input", result_o, v);
        last_res = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ok_r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk(busy_o == 1'b1, "R8 busy", busy_o, 1);
        chk(result_o == '0, "R8 result", result_o, 0);
        chk(trial_o == '0, "R8 trial", trial_o, 0);
        chk(load_o == 1'b0, "R8 load", load_o, 0);
        @(negedge clk);
        chk(trial_o == '0, "R9 trial clear idle", trial_o, 0);

        // R1: chip select falling while read/convert low starts a conversion
        cs_n = 1'b1; rc_n = 1'b0; vin = 12'h3C5;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 start on cs_n fall", busy_o, 0);
        cs_n = 1'b1;
        repeat (TRIALS + 1) @(negedge clk);
        chk(busy_o == 1'b1, "R1 conversion ends", busy_o, 1);
        chk(result_o == 12'h3C5, "R1 result via cs start", result_o, 12'h3C5);
        last_res = 12'h3C5;
        // R1: read/convert falling while chip select high does nothing
        rc_n = 1'b1;
        @(negedge clk); rc_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b1, "R1 no start with cs_n high", busy_o, 1);
        rc_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);

        // R4: extra strobe edges during conversion
        run_conv(12'h9A6, 1'b1);
        run_conv(12'h001, 1'b1);

        // R5: strobe held low through the load cycle
        vin = 12'h5A3; rc_n = 1'b0;
        @(negedge clk);
        for (int i = 1; i <= TRIALS; i++) @(negedge clk);
        chk(load_o == 1'b1, "R5 first load", load_o, 1);
        vin = 12'h1C7;
        @(negedge clk);
        chk(busy_o == 1'b0, "R5 busy stays low", busy_o, 0);
        chk(trial_o == 12'h800, "R5 restart MSB", trial_o, 12'h800);
        chk(result_o == 12'h5A3, "R5 first result", result_o, 12'h5A3);
        rc_n = 1'b1;
        ok_r = 1'b1;
        for (int i = 1; i <= TRIALS; i++) begin
            @(negedge clk);
            if (busy_o !== 1'b0 || load_o !== (i == TRIALS)) ok_r = 1'b0;
        end
        chk(ok_r, "R5 second window", ok_r, 1);
        @(negedge clk);
        chk(busy_o == 1'b1, "R5 busy high at end", busy_o, 1);
        chk(result_o == 12'h1C7, "R5 second result", result_o, 12'h1C7);
        last_res = 12'h1C7;

        // R6: power-down blocks a start
        pwrdn = 1'b1;
        @(negedge clk); rc_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy_o == 1'b1, "R6 no start under pwrdn", busy_o, 1);
        end
        chk(result_o == last_res, "R6 result kept", result_o, last_res);
        rc_n = 1'b1; pwrdn = 1'b0;
        @(negedge clk);

        // R7: power-down during the trial phase abandons the conversion
        vin = 12'h000; rc_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 started", busy_o, 0);
        rc_n = 1'b1;
        repeat (4) @(negedge clk);
        pwrdn = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b1, "R7 busy after abort", busy_o, 1);
        chk(trial_o == '0, "R7 trial cleared", trial_o, 0);
        chk(load_o == 1'b0, "R7 no load", load_o, 0);
        repeat (3) @(negedge clk);
        chk(result_o == last_res, "R7 result unchanged", result_o, last_res);
        pwrdn = 1'b0;
        @(negedge clk);

        // R2/R3: exhaustive sweep of every input code
        for (int v = 0; v < (1 << NB); v++) run_conv(NB'(v), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule